// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block sits behind a host byte link and turns a stream of 8-bit command bytes into accesses to a 256-location register space. The upper four bits of each byte select an operation and the lower four bits carry a nibble of payload. The host builds an 8-bit address and an 8-bit write value from two nibbles each. It then commits a write or launches a read at the address currently held. Read and write strobes go to the attached register space, which may decode the same address to different physical registers in the two directions.

Every read command also records an address-stepping mode. Bit 0 of its operand enables stepping and bit 1 chooses the direction, 1 for down and 0 for up. The address moves by one after the read. The recorded mode stays in force, so later committed writes step the address in the same way. Each byte returned by a read leaves through a one-entry valid/ready output. The command input stalls while that byte is still waiting to be taken.

Top module: `nibreg_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `wr_stb`, `rd_stb` and `rsp_valid` are 0, `cmd_ready` is 1, the address is 0x00, the pending low data nibble is 0 and the stepping mode is "no stepping".
- R2: An accepted byte with opcode 0x0 (bits [7:4]) copies bits [3:0] into address bits [3:0]. Opcode 0x1 copies bits [3:0] into address bits [7:4]. The other address nibble is left unchanged.
- R3: An accepted byte with opcode 0x2 stores bits [3:0] as the pending low data nibble. The nibble is kept across writes until the next opcode 0x2.
- R4: An accepted byte with opcode 0x3 produces `wr_stb`=1 for exactly the next cycle, with `wr_addr` equal to the address before any stepping and `wr_data` = {bits [3:0] of the byte, pending low nibble}.
- R5: An accepted byte with opcode 0x4 produces `rd_stb`=1 for exactly the next cycle, with `rd_addr` equal to the address before stepping. `rd_rdata` is sampled at the end of that cycle.
- R6: An opcode 0x4 operand sets the stepping mode: bit 0 = 1 steps the address after the read, bit 1 = 1 steps down and 0 steps up. With bit 0 = 0 the address is unchanged.
- R7: After a committed write (opcode 0x3) the address steps according to the mode last set by an opcode 0x4, and all stepping wraps modulo 256 (0xFF up gives 0x00, 0x00 down gives 0xFF).
- R8: The byte read in a `rd_stb` cycle appears on `rsp_data` with `rsp_valid`=1 in the following cycle. Both hold unchanged until a cycle with `rsp_ready`=1, after which `rsp_valid` drops unless a new read byte arrives.
- R9: `cmd_ready` is 0 during every `rd_stb` cycle and in every cycle where `rsp_valid`=1 and `rsp_ready`=0; otherwise it is 1. A byte counts only when `cmd_valid` and `cmd_ready` are both 1.
- R10: Accepted bytes with opcodes 0x5 to 0xF raise no strobe and leave the address, the pending nibble and the stepping mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken this cycle |
| cmd_byte | input | 8 | Opcode [7:4] and operand nibble [3:0] |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write value |
| rd_stb | output | 1 | One-cycle register read strobe |
| rd_addr | output | 8 | Read address |
| rd_rdata | input | 8 | Register value for `rd_addr`, valid during `rd_stb` |
| rsp_valid | output | 1 | Read byte waiting |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_data | output | 8 | Read byte |

## Verification
Two events can share a cycle: the host taking a held read byte and the decoder accepting a new read command. Removing the old byte is what frees the slot for the new read. The bench provokes this by issuing back-to-back reads with `rsp_ready` high in the cycle the first byte appears, then again after a stall with `rsp_ready` low. A behavioural model predicts `cmd_ready`, both strobes and the response byte every clock. The bench judges that no byte is lost or duplicated and that the stall ends in the right cycle. Address wrap in both directions and ignored opcodes are judged the same way.

// File: rtl/nibreg_pkg.sv
// Package: shared constants and decoded-command type for the nibble-serial
// register command decoder. Assumes two nibbles per address and data byte.
package nibreg_pkg;

    // Number of nibbles that make up one address or data byte.
    localparam int NIBS = 2;

    // Opcode values carried in the upper nibble of a command byte.
    localparam logic [3:0] OPC_ADDR_LO = 4'h0;
    localparam logic [3:0] OPC_ADDR_HI = 4'h1;
    localparam logic [3:0] OPC_DATA_LO = 4'h2;
    localparam logic [3:0] OPC_WRITE   = 4'h3;
    localparam logic [3:0] OPC_READ    = 4'h4;

    // Address stepping mode, bit order matches the read operand.
    typedef struct packed {
        logic down;  // 1 = step down, 0 = step up
        logic en;    // 1 = step after access
    } step_mode_t;

    // One-hot decode of an accepted command byte.
    typedef struct packed {
        logic [NIBS-1:0] ld_addr;  // load address nibble i
        logic            ld_dlo;   // latch low data nibble
        logic            commit;   // commit write
        logic            start_rd; // launch read
    } cmd_flags_t;

endpackage

// File: rtl/nibreg_cmd_split.sv
// Splits a command byte into opcode and operand and decodes the opcode into
// one-hot action flags, gated by the accept qualifier. Unlisted opcodes
// yield no flag at all. Purely combinational.
module nibreg_cmd_split
    import nibreg_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [2*NIB_W-1:0] cmd_byte,
    input  logic               accept,
    output cmd_flags_t         flags,
    output logic [NIB_W-1:0]   arg
);
    localparam int BYTE_W = 2 * NIB_W;

    logic [NIB_W-1:0] opc;

    // Separate the two halves of the byte.
    always_comb begin
        opc = cmd_byte[BYTE_W-1:NIB_W];
        arg = cmd_byte[NIB_W-1:0];
    end

    // Decode the opcode into action flags when the byte is accepted.
    always_comb begin
        flags = '0;
        if (accept) begin
            for (int i = 0; i < NIBS; i++) begin
                flags.ld_addr[i] = (opc == NIB_W'(OPC_ADDR_LO + i));
            end
            flags.ld_dlo   = (opc == NIB_W'(OPC_DATA_LO));
            flags.commit   = (opc == NIB_W'(OPC_WRITE));
            flags.start_rd = (opc == NIB_W'(OPC_READ));
        end
    end

endmodule

// File: rtl/nibreg_addr_unit.sv
// Holds the current register address as nibble registers and the sticky
// stepping mode. A read sets the mode from its operand and steps with it;
// a committed write steps with the stored mode. Stepping wraps modulo the
// address range. Assumes at most one flag is set per cycle.
module nibreg_addr_unit
    import nibreg_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cmd_flags_t             flags,
    input  logic [NIB_W-1:0]       arg,
    output logic [NIBS*NIB_W-1:0]  cur_addr
);
    localparam int ADDR_W = NIBS * NIB_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    step_mode_t        mode_q;
    step_mode_t        use_mode;
    logic [ADDR_W-1:0] stepped;
    logic [NIB_W-1:0]  nib_q [NIBS];

    // Pick the stepping mode that applies to the access of this cycle.
    always_comb begin
        use_mode = flags.start_rd ? step_mode_t'(arg[1:0]) : mode_q;
    end

    // Compute the address after an optional step up or down.
    always_comb begin
        stepped = cur_addr;
        if ((flags.start_rd || flags.commit) && use_mode.en) begin
            stepped = use_mode.down ? cur_addr - ONE : cur_addr + ONE;
        end
    end

    // Record the stepping mode carried by every read command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (flags.start_rd) begin
            mode_q <= step_mode_t'(arg[1:0]);
        end
    end

    // One register per address nibble: direct load or stepped value.
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q[g] <= '0;
            end else if (flags.ld_addr[g]) begin
                nib_q[g] <= arg;
            end else begin
                nib_q[g] <= stepped[g*NIB_W +: NIB_W];
            end
        end
        assign cur_addr[g*NIB_W +: NIB_W] = nib_q[g];
    end

endmodule

// File: rtl/nibreg_access_unit.sv
// Keeps the pending low data nibble and launches register accesses: a
// registered one-cycle write strobe with address and assembled byte, and a
// registered one-cycle read strobe with address. Addresses are taken
// before the address unit steps. Assumes two nibbles per data byte.
module nibreg_access_unit
    import nibreg_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cmd_flags_t             flags,
    input  logic [NIB_W-1:0]       arg,
    input  logic [NIBS*NIB_W-1:0]  cur_addr,
    output logic                   wr_stb,
    output logic [NIBS*NIB_W-1:0]  wr_addr,
    output logic [NIBS*NIB_W-1:0]  wr_data,
    output logic                   rd_stb,
    output logic [NIBS*NIB_W-1:0]  rd_addr
);
    logic [NIB_W-1:0] dlo_q;

    // Latch the low data nibble; it survives commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlo_q <= '0;
        end else if (flags.ld_dlo) begin
            dlo_q <= arg;
        end
    end

    // Issue the write strobe, address and byte for a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= flags.commit;
            if (flags.commit) begin
                wr_addr <= cur_addr;
                wr_data <= {arg, dlo_q};
            end
        end
    end

    // Issue the read strobe and address for a read command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stb  <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_stb <= flags.start_rd;
            if (flags.start_rd) begin
                rd_addr <= cur_addr;
            end
        end
    end

endmodule

// File: rtl/nibreg_rsp_slot.sv
// One-entry output register for read bytes with a valid/ready handshake.
// Captures the register value at the end of a read strobe cycle and holds
// it until taken. Assumes the caller never strobes while the slot is full
// and not being emptied.
module nibreg_rsp_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] rd_rdata,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    // Fill on a read strobe, empty when the host takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (rd_stb) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_rdata;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/nibreg_cmd_decoder.sv
// Top of the nibble-serial register command decoder. Accepts command bytes
// with a valid/ready handshake, decodes them, maintains address and data
// state, issues register strobes and returns read bytes. Input stalls while
// a read is in flight or a read byte is waiting, so no byte is dropped.
module nibreg_cmd_decoder
    import nibreg_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2*NIB_W-1:0]    cmd_byte,
    output logic                  wr_stb,
    output logic [NIBS*NIB_W-1:0] wr_addr,
    output logic [NIBS*NIB_W-1:0] wr_data,
    output logic                  rd_stb,
    output logic [NIBS*NIB_W-1:0] rd_addr,
    input  logic [NIBS*NIB_W-1:0] rd_rdata,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [NIBS*NIB_W-1:0] rsp_data
);
    localparam int ADDR_W = NIBS * NIB_W;

    logic              accept;
    cmd_flags_t        flags;
    logic [NIB_W-1:0]  arg;
    logic [ADDR_W-1:0] cur_addr;

    // Flow control: hold off while a read is launching or a byte waits.
    always_comb begin
        cmd_ready = !rd_stb && (!rsp_valid || rsp_ready);
        accept    = cmd_valid && cmd_ready;
    end

    nibreg_cmd_split #(.NIB_W(NIB_W)) split_i (
        .cmd_byte (cmd_byte),
        .accept   (accept),
        .flags    (flags),
        .arg      (arg)
    );

    nibreg_addr_unit #(.NIB_W(NIB_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags),
        .arg      (arg),
        .cur_addr (cur_addr)
    );

    nibreg_access_unit #(.NIB_W(NIB_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags),
        .arg      (arg),
        .cur_addr (cur_addr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr)
    );

    nibreg_rsp_slot #(.DATA_W(ADDR_W)) rsp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .rd_rdata  (rd_rdata),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/nibreg_cmd_decoder_chk.sv
// Checker for the command decoder, attached with bind. Observes the ports
// and the current address and checks the timing rules of the requirements.
module nibreg_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_byte,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_data,
    input logic [7:0] cur_addr
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    assert_low_nibble_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte[7:4] == 4'h0 |=> cur_addr[3:0] == $past(cmd_byte[3:0])
                                        && cur_addr[7:4] == $past(cur_addr[7:4]));

    assert_high_nibble_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte[7:4] == 4'h1 |=> cur_addr[7:4] == $past(cmd_byte[3:0])
                                        && cur_addr[3:0] == $past(cur_addr[3:0]));

    assert_commit_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte[7:4] == 4'h3 |=> wr_stb && !rd_stb);

    assert_read_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte[7:4] == 4'h4 |=> rd_stb && !wr_stb);

    assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte == 8'h41 |=> cur_addr == 8'($past(cur_addr) + 8'd1));

    assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte == 8'h43 |=> cur_addr == 8'($past(cur_addr) - 8'd1));

    assert_read_fills_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rsp_valid);

    assert_slot_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    assert_stall_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> !cmd_ready);

    assert_stall_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !cmd_ready);

    assert_ignored_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_byte[7:4] >= 4'h5 |=> !wr_stb && !rd_stb && $stable(cur_addr));

endmodule

bind nibreg_cmd_decoder nibreg_cmd_decoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_byte  (cmd_byte),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .cur_addr  (cur_addr)
);

// File: tb/nibreg_cmd_decoder_tb_top.sv
// Bench: behavioural reference model compared with the design every clock.
module nibreg_cmd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       rsp_ready = 1'b0;
    logic       cmd_ready, wr_stb, rd_stb, rsp_valid;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_rdata, rsp_data;

    always #10 clk = ~clk;  // 50 MHz

    nibreg_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_rdata(rd_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    // Read-side register contents, distinct from anything written.
    function automatic logic [7:0] regval(input logic [7:0] a);
        return (a * 8'd29) ^ 8'h5C;
    endfunction
    assign rd_rdata = rd_stb ? regval(rd_addr) : 8'h00;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string phase = "R1 reset";

    // Reference model state.
    int m_addr = 0, m_dlo = 0, m_mode = 0;
    bit e_wr = 0, e_rd = 0, e_rv = 0;
    int e_wa = 0, e_wd = 0, e_ra = 0, e_rdat = 0;
    int popped[$];

    function automatic int step(input int a, input int md);
        if (md % 2 == 0) return a;
        return (md >= 2) ? (a + 255) % 256 : (a + 1) % 256;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            miscompares++;
            summary();
        end
    end

    // One clock: drive, compare with model, advance model.
    task automatic cyc(input bit v, input logic [7:0] b, input bit rr, output bit acc);
        bit bad, er, n_wr, n_rd, n_rv;
        int n_wa, n_wd, n_ra, n_rdat, op, arg;
        cmd_valid = v; cmd_byte = b; rsp_ready = rr;
        #1;
        bad = 0;
        vectors++;
        if (wr_stb !== e_wr) begin bad = 1; $display("FAIL %s wr_stb act=%0d exp=%0d", phase, wr_stb, e_wr); end
        if (e_wr && (wr_addr !== 8'(e_wa) || wr_data !== 8'(e_wd))) begin
            bad = 1; $display("FAIL %s write act=%h:%h exp=%h:%h", phase, wr_addr, wr_data, 8'(e_wa), 8'(e_wd));
        end
        if (rd_stb !== e_rd) begin bad = 1; $display("FAIL %s rd_stb act=%0d exp=%0d", phase, rd_stb, e_rd); end
        if (e_rd && rd_addr !== 8'(e_ra)) begin
            bad = 1; $display("FAIL %s rd_addr act=%h exp=%h", phase, rd_addr, 8'(e_ra));
        end
        if (rsp_valid !== e_rv) begin bad = 1; $display("FAIL %s rsp_valid act=%0d exp=%0d", phase, rsp_valid, e_rv); end
        if (e_rv && rsp_data !== 8'(e_rdat)) begin
            bad = 1; $display("FAIL %s rsp_data act=%h exp=%h", phase, rsp_data, 8'(e_rdat));
        end
        er = !e_rd && (!e_rv || rr);
        if (cmd_ready !== er) begin bad = 1; $display("FAIL %s cmd_ready act=%0d exp=%0d", phase, cmd_ready, er); end
        if (bad) miscompares++;
        if (e_rv && rr) popped.push_back(e_rdat);
        n_rv = e_rd ? 1'b1 : (e_rv && !rr);
        n_rdat = e_rd ? int'(regval(8'(e_ra))) : e_rdat;
        n_wr = 0; n_rd = 0; n_wa = e_wa; n_wd = e_wd; n_ra = e_ra;
        acc = v && er;
        if (acc) begin
            op = int'(b[7:4]); arg = int'(b[3:0]);
            case (op)
                0: m_addr = (m_addr & 8'hF0) | arg;
                1: m_addr = (arg * 16) | (m_addr & 8'h0F);
                2: m_dlo = arg;
                3: begin n_wr = 1; n_wa = m_addr; n_wd = arg * 16 + m_dlo; m_addr = step(m_addr, m_mode); end
                4: begin n_rd = 1; n_ra = m_addr; m_mode = arg % 4; m_addr = step(m_addr, m_mode); end
                default: ;
            endcase
        end
        @(posedge clk); @(negedge clk);
        e_wr = n_wr; e_rd = n_rd; e_rv = n_rv; e_wa = n_wa; e_wd = n_wd; e_ra = n_ra; e_rdat = n_rdat;
    endtask

    task automatic send(input logic [7:0] b, input bit rr);
        bit a;
        do cyc(1'b1, b, rr, a); while (!a);
    endtask

    task automatic idle(input int n, input bit rr);
        bit a;
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, rr, a);
    endtask

    task automatic set_addr(input logic [7:0] a);
        send({4'h0, a[3:0]}, 1'b1);
        send({4'h1, a[7:4]}, 1'b1);
    endtask

    task automatic check_pop(input string tag, input int exp);
        vectors++;
        if (popped.size() == 0) begin
            miscompares++; $display("FAIL %s popped act=none exp=%h", tag, 8'(exp));
        end else begin
            int got = popped.pop_front();
            if (got != exp) begin miscompares++; $display("FAIL %s popped act=%h exp=%h", tag, 8'(got), 8'(exp)); end
        end
    endtask

    initial begin
        bit a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1 reset state";
        idle(2, 1'b1);
        // R1: address 0 and nibble 0 after reset, seen through a write.
        send(8'h35, 1'b1); idle(1, 1'b1);

        phase = "R2 R4 address and write";
        set_addr(8'h5A);
        send(8'h2C, 1'b1); send(8'h37, 1'b1); idle(1, 1'b1);
        phase = "R3 low nibble kept";
        send(8'h39, 1'b1); idle(1, 1'b1);

        phase = "R5 plain read";
        send(8'h40, 1'b1); idle(3, 1'b1);
        check_pop("R5", int'(regval(8'h5A)));

        phase = "R8 R9 stall while byte waits";
        send(8'h40, 1'b0); idle(4, 1'b0);
        cyc(1'b1, 8'h40, 1'b0, a);
        cyc(1'b1, 8'h40, 1'b0, a);
        send(8'h40, 1'b1); idle(3, 1'b1);
        check_pop("R8", int'(regval(8'h5A)));

        phase = "R6 step up";
        send(8'h41, 1'b1); send(8'h41, 1'b1); send(8'h41, 1'b1); idle(3, 1'b1);
        phase = "R7 write steps up";
        send(8'h2E, 1'b1); send(8'h3D, 1'b1); send(8'h3C, 1'b1); idle(1, 1'b1);

        phase = "R7 wrap up";
        set_addr(8'hFE);
        send(8'h41, 1'b1); send(8'h41, 1'b1); send(8'h40, 1'b1); idle(3, 1'b1);
        phase = "R7 wrap down";
        set_addr(8'h01);
        send(8'h43, 1'b1); send(8'h43, 1'b1); send(8'h40, 1'b1); idle(3, 1'b1);
        phase = "R7 write steps down";
        send(8'h43, 1'b1); send(8'h31, 1'b1); send(8'h32, 1'b1); send(8'h33, 1'b1); idle(1, 1'b1);

        phase = "R6 direction bit alone";
        set_addr(8'h80);
        send(8'h42, 1'b1); send(8'h40, 1'b1); send(8'h34, 1'b1); send(8'h34, 1'b1); idle(3, 1'b1);

        phase = "R10 ignored opcodes";
        set_addr(8'h33); send(8'h27, 1'b1); send(8'h41, 1'b1);
        for (int op = 5; op < 16; op++) send(8'(op * 16 + 9), 1'b1);
        idle(2, 1'b1);
        send(8'h35, 1'b1); send(8'h40, 1'b1); idle(3, 1'b1);

        phase = "R8 R9 same-cycle pop and new read";
        set_addr(8'hC0);
        send(8'h41, 1'b1); send(8'h41, 1'b1); send(8'h41, 1'b1); send(8'h40, 1'b1);
        idle(3, 1'b1);
        phase = "R8 R9 pop after stall then read";
        send(8'h41, 1'b0); idle(3, 1'b0);
        send(8'h41, 1'b1); idle(3, 1'b1);
        summary();
    end
endmodule